// File: doc/BRIEF.md
# Four-Lane Streaming Sorter with Merge Tree

The block takes up to four parallel lanes of small unsigned values. Each lane feeds its own systolic insertion chain of compare-and-swap cells, so every lane holds a locally sorted list. Once the inputs have been quiet long enough for every chain to settle, the block drains. A binary tree of two-input merge nodes then picks the largest remaining head among all lanes each cycle. The result is one stream, in non-increasing order, on a single data port with a valid flag.

A batch is the run of input cycles that starts with the first valid input after the previous drain. The batch closes once no lane has been valid for a number of cycles equal to the chain length. The default chain has four cells and one tail slot, so each lane holds five values. The caller keeps the inputs idle for at least `FLUSH_CYCLES` (chain length + lanes × lane capacity + 1) cycles after the last valid input. After that the next batch may begin.

Top module: `stream_merge_sorter`

## Requirements
- R1: While reset is high and after it is released, `out_valid` stays low until a batch has been collected. Cycles with every `in_valid` bit low produce no output.
- R2: Each lane keeps only the first five valid values (NPE+1) it samples in a batch. Further valid values on that lane in the same batch are discarded and never reach the output.
- R3: A batch closes after NPE (default 4) consecutive sampled cycles with all `in_valid` bits low. `out_valid` first goes high on the (NPE+1)th rising edge after the edge that sampled the batch's last valid input.
- R4: Successive output values of a batch are non-increasing: the largest comes first and the smallest comes last.
- R5: The values emitted for a batch are exactly the values kept from all lanes, duplicates included. Lane `l` presents its value on `in_data[4l+3:4l]`. A lane that received nothing contributes nothing.
- R6: `out_valid` is high for exactly N consecutive cycles per batch, where N is the number of values kept. It is never high outside a drain.
- R7: Valid inputs sampled while the block is draining are dropped. They do not start a new batch and never appear at the output.
- R8: Idle gaps of fewer than NPE cycles between valid inputs do not split a batch. The values on both sides of a gap are sorted together.
- R9: A valid input sampled on the first rising edge after `out_valid` has returned low is accepted into a new batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | LANES | Per-lane input valid |
| in_data | input | LANES*4 | Per-lane unsigned values, lane l at bits 4l+3:4l |
| out_valid | output | 1 | High while a sorted value is presented |
| out_data | output | 4 | Sorted output value, largest first |

## Verification
The stimulus includes a single-lane batch, which shows whether values pass cleanly through merge nodes with one empty side. A full batch of five values on every lane exercises the deepest chain and the longest drain. A lane fed seven values shows whether the capacity limit keeps the first five or lets later, larger values in. Batches made of equal values and of the extremes 0 and 15 test tie handling in both the cells and the merge nodes. Gaps of three idle cycles show whether a batch is split too early. Random inputs during a drain, and a new batch started on the first cycle after the output falls, separate correct batch boundaries from off-by-one closing. Constrained random batches with mixed lane activity and short gaps cover the remaining orderings.

// File: rtl/lms_pkg.sv
package lms_pkg;

    parameter int unsigned VAL_W = 4;

    typedef logic [VAL_W-1:0] val_t;

    typedef struct packed {
        logic vld;
        val_t val;
    } slot_t;

    localparam slot_t SLOT_EMPTY = '{vld: 1'b0, val: '0};

    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_DRAIN   = 1'b1
    } phase_e;

    // left side wins on ties or when the right side is empty
    function automatic logic left_first(slot_t a, slot_t b);
        return a.vld && (!b.vld || (a.val >= b.val));
    endfunction

endpackage

// File: rtl/lms_cas_cell.sv
module lms_cas_cell
    import lms_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t in_slot,
    input  logic  shift_en,
    input  slot_t shift_slot,
    output slot_t held,
    output slot_t passed
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= SLOT_EMPTY;
            passed <= SLOT_EMPTY;
        end else if (shift_en) begin
            // drain: move the neighbour's value up toward the lane head
            held   <= shift_slot;
            passed <= SLOT_EMPTY;
        end else if (in_slot.vld) begin
            if (!held.vld) begin
                held   <= in_slot;
                passed <= SLOT_EMPTY;
            end else if (in_slot.val > held.val) begin
                held   <= in_slot;
                passed <= held;
            end else begin
                // smaller or equal: the incoming value travels on
                passed <= in_slot;
            end
        end else begin
            passed <= SLOT_EMPTY;
        end
    end

endmodule

// File: rtl/lms_lane.sv
module lms_lane
    import lms_pkg::*;
#(
    parameter int NPE = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  val_t  in_val,
    input  logic  pop,
    input  logic  clr,
    output slot_t head,
    output logic  accepted
);

    localparam int CAP   = NPE + 1;
    localparam int CNT_W = $clog2(CAP + 1);

    logic [CNT_W-1:0] fill_cnt;
    slot_t            held   [NPE];
    slot_t            passed [NPE];
    slot_t            tail;
    slot_t            entry;

    assign accepted = take && (fill_cnt < CNT_W'(CAP));
    assign entry    = '{vld: accepted, val: in_val};
    assign head     = held[0];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fill_cnt <= '0;
        end else if (accepted) begin
            fill_cnt <= fill_cnt + 1'b1;
        end
    end

    for (genvar i = 0; i < NPE; i++) begin : g_cell
        slot_t up_slot;
        slot_t down_slot;
        if (i == 0) begin : g_first
            assign up_slot = entry;
        end else begin : g_mid
            assign up_slot = passed[i-1];
        end
        if (i == NPE - 1) begin : g_last
            assign down_slot = tail;
        end else begin : g_inner
            assign down_slot = held[i+1];
        end
        lms_cas_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .in_slot    (up_slot),
            .shift_en   (pop),
            .shift_slot (down_slot),
            .held       (held[i]),
            .passed     (passed[i])
        );
    end

    // slot past the last cell catches the value that leaves the chain
    always_ff @(posedge clk) begin
        if (rst || pop) begin
            tail <= SLOT_EMPTY;
        end else if (passed[NPE-1].vld) begin
            tail <= passed[NPE-1];
        end
    end

endmodule

// File: rtl/lms_merge2.sv
module lms_merge2
    import lms_pkg::*;
(
    input  slot_t a_slot,
    input  slot_t b_slot,
    input  logic  pop_out,
    output slot_t head,
    output logic  pop_a,
    output logic  pop_b
);

    logic a_wins;

    assign a_wins = left_first(a_slot, b_slot);
    assign head   = a_wins ? a_slot : b_slot;
    assign pop_a  = pop_out && a_wins;
    assign pop_b  = pop_out && !a_wins && b_slot.vld;

endmodule

// File: rtl/stream_merge_sorter.sv
module stream_merge_sorter
    import lms_pkg::*;
#(
    parameter int LANES = 4,
    parameter int NPE   = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES-1:0]       in_valid,
    input  logic [LANES*VAL_W-1:0] in_data,
    output logic                   out_valid,
    output logic [VAL_W-1:0]       out_data
);

    localparam int CAP          = NPE + 1;
    localparam int NODES        = 2 * LANES;
    localparam int IDLE_W       = $clog2(NPE + 1);
    localparam int FLUSH_CYCLES = NPE + LANES * CAP + 1;

    phase_e            phase;
    logic [IDLE_W-1:0] idle_cnt;
    logic              have_data;
    logic              draining;
    logic              root_vld;
    logic              drain_done;
    logic [LANES-1:0]  lane_acc;

    slot_t node_head [1:NODES-1];
    logic  node_pop  [1:NODES-1];

    assign draining   = (phase == ST_DRAIN);
    assign root_vld   = node_head[1].vld;
    assign drain_done = draining && !root_vld;
    assign node_pop[1] = draining && root_vld;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lms_lane #(.NPE(NPE)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .take     (in_valid[l] && !draining),
            .in_val   (in_data[l*VAL_W +: VAL_W]),
            .pop      (node_pop[LANES+l]),
            .clr      (drain_done),
            .head     (node_head[LANES+l]),
            .accepted (lane_acc[l])
        );
    end

    // heap-indexed tree: node k merges children 2k and 2k+1
    for (genvar k = 1; k < LANES; k++) begin : g_node
        lms_merge2 u_merge (
            .a_slot  (node_head[2*k]),
            .b_slot  (node_head[2*k+1]),
            .pop_out (node_pop[k]),
            .head    (node_head[k]),
            .pop_a   (node_pop[2*k]),
            .pop_b   (node_pop[2*k+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= ST_COLLECT;
            idle_cnt  <= '0;
            have_data <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            case (phase)
                ST_COLLECT: begin
                    out_valid <= 1'b0;
                    if (|in_valid) begin
                        idle_cnt  <= '0;
                        have_data <= 1'b1;
                    end else if (have_data) begin
                        if (idle_cnt == IDLE_W'(NPE - 1)) begin
                            phase    <= ST_DRAIN;
                            idle_cnt <= '0;
                        end else begin
                            idle_cnt <= idle_cnt + 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (root_vld) begin
                        out_valid <= 1'b1;
                        out_data  <= node_head[1].val;
                    end else begin
                        out_valid <= 1'b0;
                        have_data <= 1'b0;
                        phase     <= ST_COLLECT;
                    end
                end
                default: phase <= ST_COLLECT;
            endcase
        end
    end

endmodule

// File: rtl/stream_merge_sorter_chk.sv
module stream_merge_sorter_chk #(
    parameter int LANES = 4,
    parameter int CAP   = 5,
    parameter int VW    = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             draining,
    input logic [LANES-1:0] lane_acc,
    input logic             out_valid,
    input logic [VW-1:0]    out_data
);

    logic prev_rst = 1'b0;
    logic drain_q;
    int   acc_cnt;
    int   out_cnt;
    int   lane_n [LANES];

    always_ff @(posedge clk) begin
        prev_rst <= rst;
        if (rst) begin
            drain_q <= 1'b0;
            acc_cnt <= 0;
            out_cnt <= 0;
            for (int l = 0; l < LANES; l++) lane_n[l] <= 0;
        end else begin
            drain_q <= draining;
            if (drain_q && !draining) begin
                acc_cnt <= $countones(lane_acc);
                out_cnt <= 0;
                for (int l = 0; l < LANES; l++) lane_n[l] <= int'(lane_acc[l]);
            end else begin
                acc_cnt <= acc_cnt + $countones(lane_acc);
                out_cnt <= out_cnt + int'(out_valid);
                for (int l = 0; l < LANES; l++) lane_n[l] <= lane_n[l] + int'(lane_acc[l]);
            end
        end
    end

    always @(posedge clk) begin
        if (prev_rst && !rst) begin
            a_r1_idle_after_reset: assert (!out_valid);
        end
        if (!rst) begin
            for (int l = 0; l < LANES; l++) begin
                a_r2_lane_cap: assert (lane_n[l] <= CAP);
            end
        end
    end

    a_r4_descending: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> (out_data <= $past(out_data)));

    a_r6_quiet_outside_drain: assert property (@(posedge clk) disable iff (rst)
        !draining |=> !out_valid);

    a_r6_count_matches: assert property (@(posedge clk) disable iff (rst)
        $fell(draining) |-> (out_cnt == acc_cnt));

    a_r7_no_accept_in_drain: assert property (@(posedge clk) disable iff (rst)
        draining |-> (lane_acc == '0));

endmodule

bind stream_merge_sorter stream_merge_sorter_chk #(
    .LANES (LANES),
    .CAP   (CAP),
    .VW    (lms_pkg::VAL_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .draining  (draining),
    .lane_acc  (lane_acc),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/stream_merge_sorter_bench.sv
module stream_merge_sorter_bench;

    localparam int L   = 4;
    localparam int NPE = 4;
    localparam int CAP = NPE + 1;
    localparam int W   = 4;
    localparam int LAT = NPE + 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [L-1:0]   in_valid = '0;
    logic [L*W-1:0] in_data = '0;
    logic           out_valid;
    logic [W-1:0]   out_data;

    always #10 clk = ~clk;

    stream_merge_sorter #(.LANES(L), .NPE(NPE)) u_stream_merge_sorter (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int n_checks = 0;
    int n_errs   = 0;
    int cyc      = 0;
    bit done     = 0;
    bit last_ov;

    logic [L-1:0]   st_v [64];
    logic [L*W-1:0] st_d [64];
    int obs_v[$];
    int obs_c[$];
    int expv[$];

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic tick(input logic [L-1:0] v, input logic [L*W-1:0] d);
        in_valid = v;
        in_data  = d;
        @(negedge clk);
        cyc++;
        last_ov = out_valid;
        if (out_valid) begin
            obs_v.push_back(int'(out_data));
            obs_c.push_back(cyc);
        end
    endtask

    task automatic clear_stim();
        for (int c = 0; c < 64; c++) begin
            st_v[c] = '0;
            st_d[c] = '0;
        end
    endtask

    // expected: first CAP values per lane, sorted largest first
    task automatic build_exp(input int n);
        int cnt [L];
        expv.delete();
        for (int l = 0; l < L; l++) cnt[l] = 0;
        for (int c = 0; c < n; c++) begin
            for (int l = 0; l < L; l++) begin
                if (st_v[c][l] && cnt[l] < CAP) begin
                    cnt[l]++;
                    expv.push_back(int'(st_d[c][l*W +: W]));
                end
            end
        end
        for (int i = 1; i < expv.size(); i++) begin
            for (int j = i; j > 0; j--) begin
                if (expv[j] > expv[j-1]) begin
                    int t = expv[j];
                    expv[j]   = expv[j-1];
                    expv[j-1] = t;
                end
            end
        end
    endtask

    task automatic run_batch(input int n, input string tag, input bit junk, input bit stop_fall);
        int ld = -1;
        int bad = -1;
        obs_v.delete();
        obs_c.delete();
        build_exp(n);
        for (int c = 0; c < n; c++) begin
            if (st_v[c] != '0) ld = cyc;
            tick(st_v[c], st_d[c]);
        end
        for (int k = 0; k < 45; k++) begin
            if (junk && cyc >= ld + 5 && cyc <= ld + 4 + expv.size())
                tick('1, (L*W)'($urandom));
            else
                tick('0, '0);
            if (stop_fall && obs_v.size() > 0 && !last_ov) break;
        end
        // R6: one output per kept value
        check(obs_v.size() == expv.size(), "R6", "output count", obs_v.size(), expv.size());
        for (int i = 0; i < obs_v.size() && i < expv.size(); i++) begin
            if (bad < 0 && obs_v[i] != expv[i]) bad = i;
        end
        // R4/R5 (or the caller's requirement): values and their order
        check(bad < 0, tag, "sorted value", (bad < 0) ? 0 : obs_v[bad], (bad < 0) ? 0 : expv[bad]);
        if (obs_v.size() > 0) begin
            check(obs_c[0] == ld + LAT, "R3", "first output cycle", obs_c[0] - ld, LAT);
            check(obs_c[obs_c.size()-1] - obs_c[0] == obs_c.size() - 1, "R6",
                  "contiguous valid span", obs_c[obs_c.size()-1] - obs_c[0] + 1, obs_c.size());
        end
    endtask

    task automatic gen_random(output int n);
        int idle_run = 0;
        n = 1 + $urandom_range(11);
        for (int c = 0; c < n; c++) begin
            logic [L-1:0] v = L'($urandom);
            if (v == '0) idle_run++;
            if (idle_run >= NPE) v = L'(1) << $urandom_range(L - 1);
            if (c == n - 1 && v == '0) v = L'(1);
            if (v != '0) idle_run = 0;
            st_v[c] = v;
            st_d[c] = (L*W)'($urandom);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL R6 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd24681));
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        end
        rst = 1'b0;
        obs_v.delete();
        for (int i = 0; i < 10; i++) tick('0, '0);
        check(obs_v.size() == 0, "R1", "outputs while idle", obs_v.size(), 0);

        // single lane through merge nodes with empty siblings
        clear_stim();
        st_v[0] = 4'b0100; st_d[0] = 16'h0500;
        st_v[1] = 4'b0100; st_d[1] = 16'h0C00;
        st_v[2] = 4'b0100; st_d[2] = 16'h0700;
        run_batch(3, "R5", 0, 0);

        // every lane full
        clear_stim();
        st_v[0] = '1; st_d[0] = 16'h3F1A;
        st_v[1] = '1; st_d[1] = 16'h0C95;
        st_v[2] = '1; st_d[2] = 16'hB7E2;
        st_v[3] = '1; st_d[3] = 16'h4D06;
        st_v[4] = '1; st_d[4] = 16'h82F9;
        run_batch(5, "R5", 0, 0);

        // R2: lane 1 overfilled, late large values must be dropped
        clear_stim();
        for (int c = 0; c < 7; c++) st_v[c] = 4'b0010;
        st_d[0] = 16'h0010; st_d[1] = 16'h0020; st_d[2] = 16'h0030;
        st_d[3] = 16'h0040; st_d[4] = 16'h0050; st_d[5] = 16'h00F0; st_d[6] = 16'h00E0;
        run_batch(7, "R2", 0, 0);

        // ties and extremes
        clear_stim();
        st_v[0] = '1; st_d[0] = 16'h9999;
        st_v[1] = '1; st_d[1] = 16'h0F90;
        st_v[2] = '1; st_d[2] = 16'hF0F0;
        run_batch(3, "R5", 0, 0);

        // R8: three-cycle gaps stay within one batch
        clear_stim();
        st_v[0] = 4'b0001; st_d[0] = 16'h0003;
        st_v[2] = 4'b1000; st_d[2] = 16'hA000;
        st_v[4] = 4'b0001; st_d[4] = 16'h0008;
        st_v[8] = 4'b0001; st_d[8] = 16'h000E;
        run_batch(9, "R8", 0, 0);

        // R7: inputs during the drain are dropped
        for (int b = 0; b < 4; b++) begin
            clear_stim();
            gen_random(n);
            run_batch(n, "R7", 1, 0);
        end

        // R9: new batch right after out_valid falls
        for (int b = 0; b < 3; b++) begin
            clear_stim();
            gen_random(n);
            run_batch(n, "R9", 0, 1);
            clear_stim();
            gen_random(n);
            run_batch(n, "R9", 0, 0);
        end

        // constrained random batches
        for (int b = 0; b < 24; b++) begin
            clear_stim();
            gen_random(n);
            run_batch(n, "R5", 0, 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule